// File: doc/BRIEF.md
# Hybrid Local/Global Branch Direction Predictor

This block predicts whether a conditional branch is taken. Two component predictors run side by side. The local component keeps a separate shift register of past outcomes for each branch slot. That history indexes a table of 2-bit counters that all branches share. The global component XORs the branch index bits with one register of recent outcomes across all branches. The result selects a counter in a second table. A third table holds one 2-bit chooser counter for each branch slot. The chooser records which component has been right more often and picks the final answer.

The lookup port is purely combinational. It takes a branch index and returns a prediction in the same cycle. The update port takes a branch index and its resolved outcome. On the next clock edge it trains both counter tables, the chooser, the branch's local history and the global history. Both ports can be active in the same cycle. The lookup then sees the state from before the update. Each update recomputes the component predictions from the current state, so the caller does not carry predictions back to the block.

Top module: `hybrid_bpred`

## Requirements
- R1: After reset every counter in all three tables holds 01 (weakly not taken, chooser leaning local) and all histories are zero. Every lookup therefore predicts not taken until the first update.
- R2: Each counter saturates within 00..11. A taken outcome adds one and stops at 11. A not-taken outcome subtracts one and stops at 00. Bit 1 of a counter is its taken/not-taken prediction.
- R3: The local history for a branch is selected by index bits [LHT_IDX_W-1:0]. On update it shifts left and takes the outcome into bit 0 (1 = taken). The full history value indexes the shared local counter table.
- R4: The global counter table is indexed by the branch index XOR the zero-extended global history. The global history shifts left on every update and takes the outcome into bit 0.
- R5: The chooser is selected by index bits [CHO_IDX_W-1:0]. A value of 10 or 11 picks the global component; 00 or 01 picks the local one. It counts up when only the global component was right, counts down when only the local one was right, and holds otherwise.
- R6: A lookup in the same cycle as an update, including one to the same branch, returns the prediction from the pre-update state.
- R7: A branch that repeats the pattern taken, taken, taken, not taken reaches zero mispredictions once trained, given a local history of at least 4 bits.
- R8: While up_valid_i is low, no table or history changes, whatever up_idx_i and up_taken_i carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_idx_i | input | GIDX_W | Branch index for the lookup |
| lk_taken_o | output | 1 | Predicted direction, 1 = taken |
| up_valid_i | input | 1 | Update strobe |
| up_idx_i | input | GIDX_W | Branch index for the update |
| up_taken_i | input | 1 | Resolved outcome, 1 = taken |

## Verification
The block is driven with several kinds of traffic.

- A single always-taken branch that then turns always not-taken drives each counter into both saturation limits.
- A lone taken-taken-taken-not-taken loop branch shows that a history-based predictor learns a pattern a bare counter cannot.
- Two branches whose outcomes are tied to each other favour the global component, which moves the chooser toward it.
- Random branches and outcomes, with lookups aimed at the branch being updated, probe how the tables alias and confirm that a lookup reads the pre-update state.
- Idle cycles carrying junk update data must leave every later prediction unchanged.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_WEAK_NT = 2'b01;
  localparam ctr2_t CTR_MAX     = 2'b11;
  localparam ctr2_t CTR_MIN     = 2'b00;

  function automatic ctr2_t ctr_step(input ctr2_t c, input logic up);
    ctr2_t r;
    if (up) r = (c == CTR_MAX) ? c : c + 2'd1;
    else    r = (c == CTR_MIN) ? c : c - 2'd1;
    return r;
  endfunction
endpackage

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
  import bp_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_a_idx_i,
  output ctr2_t            rd_a_o,
  input  logic [IDX_W-1:0] rd_b_idx_i,
  output ctr2_t            rd_b_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_up_i
);
  localparam int DEPTH = 1 << IDX_W;

  ctr2_t ctr_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   ctr_q[e] <= CTR_WEAK_NT;
      else if (wr_en_i && wr_idx_i == IDX_W'(e))    ctr_q[e] <= ctr_step(ctr_q[e], wr_up_i);
    end
  end

  assign rd_a_o = ctr_q[rd_a_idx_i];
  assign rd_b_o = ctr_q[rd_b_idx_i];

  assert_sat_hi_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_up_i && ctr_q[wr_idx_i] == CTR_MAX) |=> ctr_q[$past(wr_idx_i)] == CTR_MAX);
  assert_sat_lo_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_up_i && ctr_q[wr_idx_i] == CTR_MIN) |=> ctr_q[$past(wr_idx_i)] == CTR_MIN);
endmodule

// File: rtl/bp_local_hist.sv
module bp_local_hist #(
  parameter int IDX_W  = 6,
  parameter int HIST_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  lk_idx_i,
  output logic [HIST_W-1:0] lk_hist_o,
  input  logic [IDX_W-1:0]  up_idx_i,
  output logic [HIST_W-1:0] up_hist_o,
  input  logic              up_en_i,
  input  logic              up_taken_i
);
  localparam int DEPTH = 1 << IDX_W;

  logic [HIST_W-1:0] hist_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 hist_q[e] <= '0;
      else if (up_en_i && up_idx_i == IDX_W'(e))  hist_q[e] <= {hist_q[e][HIST_W-2:0], up_taken_i};
    end
  end

  assign lk_hist_o = hist_q[lk_idx_i];
  assign up_hist_o = hist_q[up_idx_i];

  assert_lhist_shift_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_en_i |=> hist_q[$past(up_idx_i)][0] == $past(up_taken_i));
endmodule

// File: rtl/hybrid_bpred.sv
module hybrid_bpred
  import bp_pkg::*;
#(
  parameter int GIDX_W    = 8,
  parameter int GHIST_W   = 8,
  parameter int LHT_IDX_W = 6,
  parameter int LHIST_W   = 6,
  parameter int CHO_IDX_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [GIDX_W-1:0] lk_idx_i,
  output logic              lk_taken_o,
  input  logic              up_valid_i,
  input  logic [GIDX_W-1:0] up_idx_i,
  input  logic              up_taken_i
);
  localparam int GH_PAD = GIDX_W - GHIST_W;

  logic [GHIST_W-1:0] ghist_q;
  logic [LHIST_W-1:0] lk_lhist, up_lhist;
  logic [GIDX_W-1:0]  lk_gidx, up_gidx;
  ctr2_t lk_lctr, up_lctr, lk_gctr, up_gctr, lk_cho, up_cho;
  logic  up_loc_ok, up_glb_ok;

  assign lk_gidx = lk_idx_i ^ {{GH_PAD{1'b0}}, ghist_q};
  assign up_gidx = up_idx_i ^ {{GH_PAD{1'b0}}, ghist_q};

  bp_local_hist #(.IDX_W(LHT_IDX_W), .HIST_W(LHIST_W)) u_lht (
    .clk_i, .rst_ni,
    .lk_idx_i  (lk_idx_i[LHT_IDX_W-1:0]),
    .lk_hist_o (lk_lhist),
    .up_idx_i  (up_idx_i[LHT_IDX_W-1:0]),
    .up_hist_o (up_lhist),
    .up_en_i   (up_valid_i),
    .up_taken_i
  );

  bp_ctr_table #(.IDX_W(LHIST_W)) u_lpht (
    .clk_i, .rst_ni,
    .rd_a_idx_i (lk_lhist), .rd_a_o (lk_lctr),
    .rd_b_idx_i (up_lhist), .rd_b_o (up_lctr),
    .wr_en_i    (up_valid_i),
    .wr_idx_i   (up_lhist),
    .wr_up_i    (up_taken_i)
  );

  bp_ctr_table #(.IDX_W(GIDX_W)) u_gpht (
    .clk_i, .rst_ni,
    .rd_a_idx_i (lk_gidx), .rd_a_o (lk_gctr),
    .rd_b_idx_i (up_gidx), .rd_b_o (up_gctr),
    .wr_en_i    (up_valid_i),
    .wr_idx_i   (up_gidx),
    .wr_up_i    (up_taken_i)
  );

  assign up_loc_ok = (up_lctr[1] == up_taken_i);
  assign up_glb_ok = (up_gctr[1] == up_taken_i);

  // chooser counts toward global when only global was right
  bp_ctr_table #(.IDX_W(CHO_IDX_W)) u_cho (
    .clk_i, .rst_ni,
    .rd_a_idx_i (lk_idx_i[CHO_IDX_W-1:0]), .rd_a_o (lk_cho),
    .rd_b_idx_i (up_idx_i[CHO_IDX_W-1:0]), .rd_b_o (up_cho),
    .wr_en_i    (up_valid_i && (up_loc_ok != up_glb_ok)),
    .wr_idx_i   (up_idx_i[CHO_IDX_W-1:0]),
    .wr_up_i    (up_glb_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ghist_q <= '0;
    else if (up_valid_i) ghist_q <= {ghist_q[GHIST_W-2:0], up_taken_i};
  end

  assign lk_taken_o = lk_cho[1] ? lk_gctr[1] : lk_lctr[1];

  assert_ghist_shift_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_valid_i |=> ghist_q[0] == $past(up_taken_i));
  assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !up_valid_i |=> $stable(ghist_q));
  assert_cho_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_valid_i && up_loc_ok == up_glb_ok && lk_idx_i[CHO_IDX_W-1:0] == up_idx_i[CHO_IDX_W-1:0])
    |=> lk_cho == $past(lk_cho) || lk_idx_i[CHO_IDX_W-1:0] != $past(up_idx_i[CHO_IDX_W-1:0]));
endmodule

// File: tb/hybrid_bpred_test.sv
`timescale 1ns/1ps
module hybrid_bpred_test;
  localparam int GIDX_W = 8, GHIST_W = 8, LHT_IDX_W = 6, LHIST_W = 6, CHO_IDX_W = 6;

  logic clk = 0, rst_n = 0;
  logic [GIDX_W-1:0] lk_idx = '0, up_idx = '0;
  logic up_valid = 0, up_taken = 0;
  logic lk_taken;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  bit last_pred;

  int lht [1<<LHT_IDX_W];
  int lpht[1<<LHIST_W];
  int gpht[1<<GIDX_W];
  int cho [1<<CHO_IDX_W];
  int ghist;

  always #2 clk = ~clk;

  hybrid_bpred #(.GIDX_W(GIDX_W), .GHIST_W(GHIST_W), .LHT_IDX_W(LHT_IDX_W),
                 .LHIST_W(LHIST_W), .CHO_IDX_W(CHO_IDX_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .lk_idx_i(lk_idx), .lk_taken_o(lk_taken),
    .up_valid_i(up_valid), .up_idx_i(up_idx), .up_taken_i(up_taken));

  function automatic int sat(int c, bit t);
    if (t) return (c < 3) ? c + 1 : 3;
    return (c > 0) ? c - 1 : 0;
  endfunction

  function automatic bit m_loc(int a);
    return lpht[lht[a % (1<<LHT_IDX_W)]] >= 2;
  endfunction
  function automatic bit m_glb(int a);
    return gpht[(a ^ ghist) % (1<<GIDX_W)] >= 2;
  endfunction
  function automatic bit m_pred(int a);
    return (cho[a % (1<<CHO_IDX_W)] >= 2) ? m_glb(a) : m_loc(a);
  endfunction

  task automatic m_reset();
    foreach (lht[i])  lht[i]  = 0;
    foreach (lpht[i]) lpht[i] = 1;
    foreach (gpht[i]) gpht[i] = 1;
    foreach (cho[i])  cho[i]  = 1;
    ghist = 0;
  endtask

  task automatic m_update(int a, bit t);
    bit lo = m_loc(a), go = m_glb(a);
    int li = a % (1<<LHT_IDX_W);
    int gi = (a ^ ghist) % (1<<GIDX_W);
    int ci = a % (1<<CHO_IDX_W);
    lpht[lht[li]] = sat(lpht[lht[li]], t);
    gpht[gi] = sat(gpht[gi], t);
    if ((lo == t) != (go == t)) cho[ci] = sat(cho[ci], go == t);
    lht[li] = ((lht[li] << 1) | t) % (1<<LHIST_W);
    ghist = ((ghist << 1) | t) % (1<<GHIST_W);
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // called just after a negedge; compares then advances one clock
  task automatic step(int la, bit uv, int ua, bit ut, string req);
    bit exp;
    lk_idx = GIDX_W'(la); up_valid = uv; up_idx = GIDX_W'(ua); up_taken = ut;
    #1;
    exp = m_pred(la);
    last_pred = lk_taken;
    check(lk_taken == exp, req, lk_taken, exp);
    @(posedge clk);
    if (uv) m_update(ua, ut);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int miss;
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: everything predicts not taken out of reset
    for (int a = 0; a < 16; a++) begin
      lk_idx = GIDX_W'(a * 13); #1;
      check(lk_taken == 1'b0, "R1", lk_taken, 0);
      @(negedge clk);
    end

    // R2: saturate up, then down
    for (int i = 0; i < 10; i++) step(3, 1, 3, 1, "R2");
    for (int i = 0; i < 10; i++) step(3, 1, 3, 0, "R2");

    // R7: taken,taken,taken,not taken loop branch
    miss = 0;
    for (int it = 0; it < 40; it++)
      for (int k = 0; k < 4; k++) begin
        step(9, 1, 9, (k != 3), "R7");
        if (it >= 20 && last_pred != (k != 3)) miss++;
      end
    check(miss == 0, "R7", miss, 0);

    // R4/R5: second branch copies the first one's random outcome
    for (int i = 0; i < 200; i++) begin
      bit t = 1'($urandom);
      step(20, 1, 20, t, "R4");
      step(37, 1, 37, t, "R5");
    end

    // R6/R3: random traffic, lookup aimed at the updated branch
    for (int i = 0; i < 2000; i++) begin
      int a = int'($urandom % (1<<GIDX_W));
      step(a, 1, a, 1'($urandom), "R6");
      step(int'($urandom % (1<<GIDX_W)), 1, int'($urandom % 16), 1'($urandom), "R3");
    end

    // R8: junk on update port with valid low, then probe everything
    for (int i = 0; i < 200; i++)
      step(int'($urandom % (1<<GIDX_W)), 0, int'($urandom), 1'($urandom), "R8");
    for (int a = 0; a < (1<<GIDX_W); a++) step(a, 0, 0, 1, "R8");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule